// File: doc/BRIEF.md
# Demux and Broadcast Queue Bank

A bank of four on-chip queues fed from a single write port and drained through four separate 10-bit read ports. Each incoming word is 10, 20 or 40 bits wide and is cut into 10-bit entries. The least significant slice is stored first. The cut is chosen by the width setting. Every read port pops only its own queue and runs independently of the other three. All ports share one clock.

The bank runs in one of two routing modes. In demux mode a 2-bit select names the single queue that takes the write. In broadcast mode the select is ignored and the write lands in all four queues at once, or in none. Mode, width and read timing (standard registered output or first-word-fall-through) are captured while master reset is held low. They then stay fixed. Each queue can be emptied on its own by a per-queue partial reset. Composite empty and full flags follow the queue named by the select input.

The write controller is a small state machine with three states:

- `ST_LOAD` is the state held during master reset and for the first cycle after it. It takes no writes.
- After that cycle the controller takes one of two transitions, load-to-demux or load-to-broadcast, according to the captured mode.
- It then stays in `ST_DEMUX` or `ST_BCAST` until the next master reset.

Top module: `qb_bank`

## Requirements
- R1: The captured width code 0 stores one 10-bit entry per write, code 1 stores two and codes 2 and 3 store four. The entries are taken from `wr_data` bits [9:0] first, then [19:10], [29:20] and [39:30].
- R2: In demux mode an accepted write goes only into the queue whose index is on `wr_sel`. The other three queues are left unchanged.
- R3: In broadcast mode `wr_sel` has no effect, and an accepted write stores the same entries into all four queues in the same cycle.
- R4: In broadcast mode a write is refused by every queue when any queue has fewer free places than the entries of one write, or when any queue's partial reset is asserted.
- R5: In demux mode a write is dropped when the addressed queue has fewer free places than the entries of one write, or when its partial reset is asserted. The other queues are left unchanged.
- R6: In standard timing, `rd_en[i]` on a non-empty queue i pops its head, and the popped entry appears on slice i of `rd_data` on the next cycle and holds until the next pop. `rd_en[i]` on an empty queue changes nothing.
- R7: In first-word-fall-through timing, slice i of `rd_data` shows the head of queue i whenever that queue is not empty, and `rd_en[i]` pops it.
- R8: Per-queue flags track occupancy n of DEPTH entries:
  - empty when n = 0;
  - full when n = DEPTH;
  - almost-empty when n <= AE_OFF;
  - almost-full when n >= DEPTH - AF_OFF.
- R9: `sel_empty` and `sel_full` equal the empty and full flags of the queue indexed by `wr_sel`.
- R10: Asserting `q_prst[i]` at a clock edge empties queue i at that edge, overriding a read or write to it. The other queues and the captured settings are unchanged.
- R11: Mode, width and timing inputs are sampled only while `rst_n` is low. Writes in the first cycle after release are ignored.
- R12: Master reset leaves every queue empty, not full, almost-empty and not almost-full, with `rd_data` all zero in standard timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Master reset, active low, synchronous; settings sampled while low |
| cfg_bcast | input | 1 | 1 selects broadcast mode, 0 demux |
| cfg_width | input | 2 | Write width code: 0 x10, 1 x20, 2/3 x40 |
| cfg_fwft | input | 1 | 1 selects first-word-fall-through read timing |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Target queue in demux mode; composite flag select |
| wr_data | input | 40 | Write word, least significant slice stored first |
| q_prst | input | 4 | Per-queue partial reset |
| rd_en | input | 4 | Per-queue read enable |
| rd_data | output | 40 | Queue i read data on bits [10i+9:10i] |
| q_empty | output | 4 | Per-queue empty |
| q_full | output | 4 | Per-queue full |
| q_aempty | output | 4 | Per-queue almost-empty |
| q_afull | output | 4 | Per-queue almost-full |
| sel_empty | output | 1 | Empty flag of queue `wr_sel` |
| sel_full | output | 1 | Full flag of queue `wr_sel` |

## Verification
The assertions check several rules on every clock:
- demux grants are at most one-hot;
- a broadcast grant covers either all four queues or none, and a partial reset blocks it;
- no write is granted to a queue without room, and occupancy never exceeds the depth;
- a partial reset empties its queue;
- the load state grants nothing and the captured width never moves.

Only the bench's scenarios can show that the data order through each queue, the slice order of wide writes and the timing of both read modes are right. The same holds for flag thresholds and composite flags, and for the insensitivity to setting pins changing after reset. The bench compares these against a reference model of the four queues.

// File: rtl/qb_pkg.sv
package qb_pkg;
    localparam int SLICE_W    = 10;
    localparam int NUM_Q      = 4;
    localparam int MAX_SLICES = 4;
    localparam int WIDE_W     = SLICE_W * MAX_SLICES;
    localparam int SEL_W      = $clog2(NUM_Q);
    localparam int NENT_W     = $clog2(MAX_SLICES) + 1;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_DEMUX = 2'd1,
        ST_BCAST = 2'd2
    } wr_state_t;
endpackage

// File: rtl/qb_write_ctrl.sv
module qb_write_ctrl
    import qb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bcast,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_fwft,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [NUM_Q-1:0]  q_room,
    input  logic [NUM_Q-1:0]  q_prst,
    output logic [NUM_Q-1:0]  q_go,
    output logic [NENT_W-1:0] n_ent,
    output logic              mode_fwft
);
    wr_state_t  state, state_nx;
    logic       bcast_q;
    logic [1:0] width_q;
    logic       fwft_q;

    // state register and settings capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_LOAD;
            bcast_q <= cfg_bcast;
            width_q <= cfg_width;
            fwft_q  <= cfg_fwft;
        end else begin
            state   <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:  state_nx = bcast_q ? ST_BCAST : ST_DEMUX;
            ST_DEMUX: state_nx = ST_DEMUX;
            ST_BCAST: state_nx = ST_BCAST;
            default:  state_nx = ST_LOAD;
        endcase
    end

    // output process: write grants per queue
    always_comb begin
        q_go = '0;
        unique case (state)
            ST_LOAD: q_go = '0;
            ST_DEMUX: begin
                if (wr_en && q_room[wr_sel] && !q_prst[wr_sel])
                    q_go[wr_sel] = 1'b1;
            end
            ST_BCAST: begin
                if (wr_en && (&q_room) && !(|q_prst))
                    q_go = '1;
            end
            default: q_go = '0;
        endcase
    end

    always_comb begin
        unique case (width_q)
            2'd0:    n_ent = NENT_W'(1);
            2'd1:    n_ent = NENT_W'(2);
            default: n_ent = NENT_W'(MAX_SLICES);
        endcase
    end

    assign mode_fwft = fwft_q;

    AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEMUX) |-> $onehot0(q_go));                     // R2
    AST_BCAST_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BCAST) |-> (q_go == '0 || q_go == '1));         // R3
    AST_BCAST_PRST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BCAST && (|q_prst)) |-> (q_go == '0));          // R4
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (q_go == '0));                        // R11
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |-> $stable(width_q));                    // R11
endmodule

// File: rtl/qb_queue.sv
module qb_queue
    import qb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AE_OFF = 2,
    parameter int AF_OFF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prst,
    input  logic               fwft,
    input  logic               wr_go,
    input  logic [NENT_W-1:0]  n_ent,
    input  logic [WIDE_W-1:0]  wr_data,
    output logic               q_room,
    input  logic               rd_en,
    output logic [SLICE_W-1:0] rd_data,
    output logic               empty,
    output logic               full,
    output logic               aempty,
    output logic               afull
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [SLICE_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wptr, rptr;
    logic [CW-1:0]      cnt;
    logic [SLICE_W-1:0] rd_q;
    logic               do_rd, do_wr;

    assign do_rd  = rd_en && !empty && !prst;
    assign do_wr  = wr_go && !prst;
    assign q_room = (CW'(DEPTH) - cnt) >= CW'(n_ent);

    // storage: up to MAX_SLICES entries per write, low slice first
    always_ff @(posedge clk) begin
        if (do_wr) begin
            for (int i = 0; i < MAX_SLICES; i++) begin
                if (NENT_W'(i) < n_ent)
                    mem[wptr + AW'(i)] <= wr_data[i*SLICE_W +: SLICE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            rd_q <= '0;
        end else if (prst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_rd) begin
                rptr <= rptr + AW'(1);
                rd_q <= mem[rptr];
            end
            if (do_wr)
                wptr <= wptr + AW'(n_ent);
            cnt <= cnt + (do_wr ? CW'(n_ent) : CW'(0)) - (do_rd ? CW'(1) : CW'(0));
        end
    end

    assign rd_data = fwft ? mem[rptr] : rd_q;
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign aempty  = (cnt <= CW'(AE_OFF));
    assign afull   = (cnt >= CW'(DEPTH - AF_OFF));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));                                          // R8
    AST_GRANT_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> q_room);                                           // R5
    AST_PRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        prst |=> empty);                                             // R10
    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_go && !prst) |=> empty);              // R6
endmodule

// File: rtl/qb_bank.sv
module qb_bank
    import qb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AE_OFF = 2,
    parameter int AF_OFF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bcast,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_fwft,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [39:0]       wr_data,
    input  logic [3:0]        q_prst,
    input  logic [3:0]        rd_en,
    output logic [39:0]       rd_data,
    output logic [3:0]        q_empty,
    output logic [3:0]        q_full,
    output logic [3:0]        q_aempty,
    output logic [3:0]        q_afull,
    output logic              sel_empty,
    output logic              sel_full
);
    logic [NUM_Q-1:0]  q_go;
    logic [NUM_Q-1:0]  q_room;
    logic [NENT_W-1:0] n_ent;
    logic              mode_fwft;

    qb_write_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_bcast (cfg_bcast),
        .cfg_width (cfg_width),
        .cfg_fwft  (cfg_fwft),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .q_room    (q_room),
        .q_prst    (q_prst),
        .q_go      (q_go),
        .n_ent     (n_ent),
        .mode_fwft (mode_fwft)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        qb_queue #(
            .DEPTH  (DEPTH),
            .AE_OFF (AE_OFF),
            .AF_OFF (AF_OFF)
        ) u_queue (
            .clk     (clk),
            .rst_n   (rst_n),
            .prst    (q_prst[g]),
            .fwft    (mode_fwft),
            .wr_go   (q_go[g]),
            .n_ent   (n_ent),
            .wr_data (wr_data),
            .q_room  (q_room[g]),
            .rd_en   (rd_en[g]),
            .rd_data (rd_data[g*SLICE_W +: SLICE_W]),
            .empty   (q_empty[g]),
            .full    (q_full[g]),
            .aempty  (q_aempty[g]),
            .afull   (q_afull[g])
        );
    end

    assign sel_empty = q_empty[wr_sel];
    assign sel_full  = q_full[wr_sel];
endmodule

// File: tb/tb_qb_bank.sv
module tb_qb_bank;
    localparam int DEPTH = 16;
    localparam int AE = 2;
    localparam int AF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bcast = 1'b0, cfg_fwft = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [39:0] wr_data = '0;
    logic [3:0]  q_prst = '0, rd_en = '0;
    logic [39:0] rd_data;
    logic [3:0]  q_empty, q_full, q_aempty, q_afull;
    logic        sel_empty, sel_full;

    qb_bank #(.DEPTH(DEPTH), .AE_OFF(AE), .AF_OFF(AF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_bcast(cfg_bcast), .cfg_width(cfg_width),
        .cfg_fwft(cfg_fwft), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .q_prst(q_prst), .rd_en(rd_en), .rd_data(rd_data), .q_empty(q_empty),
        .q_full(q_full), .q_aempty(q_aempty), .q_afull(q_afull),
        .sel_empty(sel_empty), .sel_full(sel_full)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [9:0] mq [4][$];
    logic [9:0] exp_rd [4];
    string      tagq [4];
    bit         m_bcast, m_fwft, loading;
    logic [1:0] m_width;

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nent_of(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    // reference update for one clock edge, using the pre-edge model state
    task automatic model_edge();
        bit go [4];
        bit all_room = 1'b1;
        int n = nent_of(m_width);
        for (int q = 0; q < 4; q++) begin
            go[q] = 1'b0;
            if (mq[q].size() + n > DEPTH) all_room = 1'b0;
        end
        if (!loading && wr_en) begin
            if (m_bcast) begin
                if (all_room && q_prst == 4'd0)
                    for (int q = 0; q < 4; q++) go[q] = 1'b1;
            end else if (mq[wr_sel].size() + n <= DEPTH && !q_prst[wr_sel]) begin
                go[wr_sel] = 1'b1;
            end
        end
        for (int q = 0; q < 4; q++) begin
            if (q_prst[q]) tagq[q] = "R10";
            else if (loading) tagq[q] = "R11";
            else if (m_bcast && wr_en) tagq[q] = go[q] ? "R3" : "R4";
            else if (!m_bcast && wr_en && wr_sel == 2'(q)) tagq[q] = go[q] ? "R2" : "R5";
            else if (!m_bcast && wr_en) tagq[q] = "R2";
            else tagq[q] = "R8";
            if (q_prst[q]) begin
                mq[q].delete();
            end else begin
                if (rd_en[q] && mq[q].size() > 0) begin
                    exp_rd[q] = mq[q][0];
                    void'(mq[q].pop_front());
                end
                if (go[q])
                    for (int i = 0; i < n; i++) mq[q].push_back(wr_data[i*10 +: 10]);
            end
        end
        loading = 1'b0;
    endtask

    task automatic check_outputs();
        for (int q = 0; q < 4; q++) begin
            int sz = mq[q].size();
            chk(q_empty[q] == (sz == 0), tagq[q], 40'(q_empty[q]), 40'(sz == 0));
            chk(q_full[q] == (sz == DEPTH), tagq[q], 40'(q_full[q]), 40'(sz == DEPTH));
            chk(q_aempty[q] == (sz <= AE), "R8", 40'(q_aempty[q]), 40'(sz <= AE));
            chk(q_afull[q] == (sz >= DEPTH - AF), "R8", 40'(q_afull[q]), 40'(sz >= DEPTH - AF));
            if (!m_fwft)
                chk(rd_data[q*10 +: 10] == exp_rd[q], (m_width == 2'd0) ? "R6" : "R1",
                    40'(rd_data[q*10 +: 10]), 40'(exp_rd[q]));
            else if (sz > 0)
                chk(rd_data[q*10 +: 10] == mq[q][0], (m_width == 2'd0) ? "R7" : "R1",
                    40'(rd_data[q*10 +: 10]), 40'(mq[q][0]));
        end
        chk(sel_empty == (mq[wr_sel].size() == 0), "R9", 40'(sel_empty), 40'(mq[wr_sel].size() == 0));
        chk(sel_full == (mq[wr_sel].size() == DEPTH), "R9", 40'(sel_full), 40'(mq[wr_sel].size() == DEPTH));
    endtask

    task automatic do_reset(input bit b, input logic [1:0] w, input bit f);
        @(negedge clk);
        rst_n = 1'b0; cfg_bcast = b; cfg_width = w; cfg_fwft = f;
        wr_en = 1'b0; rd_en = '0; q_prst = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_bcast = b; m_width = w; m_fwft = f; loading = 1'b1;
        for (int q = 0; q < 4; q++) begin
            mq[q].delete();
            exp_rd[q] = '0;
            chk(q_empty[q] && !q_full[q] && q_aempty[q] && !q_afull[q], "R12",
                40'({q_empty[q], q_full[q], q_aempty[q], q_afull[q]}), 40'b1010);
            if (!f) chk(rd_data[q*10 +: 10] == 10'd0, "R12", 40'(rd_data[q*10 +: 10]), 40'd0);
        end
        // R11: write presented in the first cycle after release is ignored
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 40'h12_3456_789A;
        cfg_bcast = ~b; cfg_width = ~w; cfg_fwft = ~f;
        @(posedge clk); model_edge();
        @(negedge clk); check_outputs();
    endtask

    task automatic run_phase(input int cycles, input int rd_pct, input int prst_pct);
        for (int c = 0; c < cycles; c++) begin
            wr_en   = ($urandom % 100) < 60;
            wr_sel  = 2'($urandom);
            wr_data = 40'({$urandom(), $urandom()});
            for (int q = 0; q < 4; q++) begin
                rd_en[q]  = ($urandom % 100) < rd_pct;
                q_prst[q] = ($urandom % 100) < prst_pct;
            end
            cfg_bcast = 1'($urandom); cfg_width = 2'($urandom); cfg_fwft = 1'($urandom);
            @(posedge clk); model_edge();
            @(negedge clk); check_outputs();
        end
        wr_en = 1'b0; rd_en = '0; q_prst = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 4; w++)
                for (int f = 0; f < 2; f++) begin
                    do_reset(1'(b), 2'(w), 1'(f));
                    run_phase(60, 0, 2);
                    run_phase(200, 40, 2);
                    run_phase(60, 90, 1);
                end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule